// File: doc/BRIEF.md
# Logical-Layer Error Capture Unit

This unit collects error reports from the packet decoders of an endpoint. Each decoder raises a one-cycle pulse on its own line of a ten-line error bus. With the pulse it presents the fields of the packet that caused the error: address, extended address bits, destination and source device IDs, format type, transaction type and message info. Every pulse sets a sticky flag in a detect register. An enable register decides which flags count as reportable. Any reportable flag raises a maintenance interrupt.

The first enabled error freezes a snapshot of the offending packet into up to three capture registers: address, device-ID and control. The kind of error decides which of the three are loaded. The snapshot stays locked, and later errors leave it untouched, until software returns the detect register to all zeros. Software reaches all five registers through a small select/write/read port. Reads are combinational and writes are single-cycle.

The parameter `WIDE_ID` chooses whether the upper byte of each 16-bit device ID is kept or always reads as zero.

Top module: `errcap_top`

## Requirements
- R1: A pulse on `errPulse[i]` sets detect bit 22+i at the next clock edge, and the bit stays set until software writes it to zero. `errPulse[7]` (detect bit 29) is ignored.
- R2: In the detect register (select 0) and the enable register (select 1), bit 29 and bits 21:0 always read zero. The enable register reads back what was written in bits 31:30 and 28:22. Writes to the capture registers (selects 2 to 4) have no effect.
- R3: `mntIrq` is high from the cycle after an enabled error pulse. It stays high while any detect bit has its enable bit set.
- R4: `mntIrq` is low in the cycle after software writes zero to the detect register, provided no pulse arrives in that cycle.
- R5: An enabled error arriving while no snapshot is held loads the capture registers and sets the lock. While the lock is held, later errors change no capture register.
- R6: The lock is released when the detect register becomes all zeros. The next enabled error then loads a new snapshot.
- R7: Which registers are loaded depends on the error. Response timeout (bit 24) loads the address register and the destination-ID half (bits 31:16) of the device-ID register. I/O error response (bit 31), message error response (bit 30) and message format error (bit 28) load all three registers. Bits 27, 26, 25, 23 and 22 load the device-ID and control registers.
- R8: When several pulses arrive in the same cycle, all of their detect bits are set. The highest-numbered enabled bit among them selects the registers that are loaded.
- R9: The address capture register (select 2) holds packet address bits 31:3 in bits 31:3, zero in bit 2, and the two extended address bits in bits 1:0.
- R10: The device-ID capture register (select 3) holds the destination ID in bits 31:16 and the source ID in bits 15:0. When `WIDE_ID` is 0, bits 31:24 and 15:8 read zero.
- R11: The control capture register (select 4) holds the format type in bits 31:28, the transaction type in bits 27:24 and the message info in bits 23:16. Bits 15:0 read zero.
- R12: A pulse whose enable bit is clear sets its detect bit but raises no interrupt and loads no capture register.
- R13: After reset, all five registers read zero and `mntIrq` is low. Select values 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| errPulse | input | 10 | One-cycle error pulses; line i maps to detect bit 22+i |
| pktAddr | input | 29 | Address bits 31:3 of the offending packet |
| pktXaddr | input | 2 | Extended address bits of the offending packet |
| pktDestId | input | 16 | Destination device ID |
| pktSrcId | input | 16 | Source device ID |
| pktFtype | input | 4 | Format type |
| pktTtype | input | 4 | Transaction type |
| pktMsgInfo | input | 8 | Message letter, mailbox and segment info |
| regSel | input | 3 | Register select (0 detect, 1 enable, 2 address, 3 device-ID, 4 control) |
| regWrEn | input | 1 | Write strobe for the selected register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of the selected register |
| mntIrq | output | 1 | Maintenance interrupt |

## Verification
The bench builds two copies of the unit on the same stimulus: `u0` with `WIDE_ID` = 1 and `u1` with `WIDE_ID` = 0. The wide copy puts the full 16-bit ID layout within reach. The narrow copy shows that the upper ID bytes are forced to zero while every other field behaves the same. The bench drives distinct packet fields for every error event, so a register that loads when it should not, or fails to load when it should, shows up as a value mismatch. The vectors cover each error class, simultaneous pulses with mixed enables, the ignored bit 29, and the lock and release sequence.

// File: rtl/errcap_pkg.sv
package errcap_pkg;
  localparam int REG_W   = 32;
  localparam int NUM_ERR = 10;
  localparam int ERR_LSB = REG_W - NUM_ERR;
  localparam int IDX_W   = $clog2(NUM_ERR);

  // lines that exist; line 7 (bit 29) is not implemented
  localparam logic [NUM_ERR-1:0] IMPL_MASK  = 10'b11_0111_1111;
  // error classes by line index
  localparam logic [NUM_ERR-1:0] CLASS_ALL  = 10'b11_0100_0000;
  localparam logic [NUM_ERR-1:0] CLASS_ADDR = 10'b00_0000_0100;

  typedef enum logic [2:0] {
    SEL_DETECT = 3'd0,
    SEL_ENABLE = 3'd1,
    SEL_ADDR   = 3'd2,
    SEL_DEVID  = 3'd3,
    SEL_CTRL   = 3'd4
  } regSel_e;

  typedef struct packed {
    logic loadAddr;
    logic loadDest;
    logic loadSrc;
    logic loadCtrl;
  } capStrobe_t;
endpackage

// File: rtl/errcap_ctrl.sv
module errcap_ctrl
  import errcap_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_ERR-1:0] errPulse,
  input  logic               wrDetect,
  input  logic               wrEnable,
  input  logic [NUM_ERR-1:0] wrField,
  output logic [NUM_ERR-1:0] detectQ,
  output logic [NUM_ERR-1:0] enableQ,
  output logic               lockQ,
  output capStrobe_t         strobe,
  output logic               irq
);
  logic [NUM_ERR-1:0] pulseLegal;
  logic [NUM_ERR-1:0] detectD;
  logic [NUM_ERR-1:0] enableD;
  logic [NUM_ERR-1:0] hits;
  logic [IDX_W-1:0]   topIdx;
  logic               captureNow;
  logic               lockD;

  assign pulseLegal = errPulse & IMPL_MASK;
  assign detectD    = (wrDetect ? (wrField & IMPL_MASK) : detectQ) | pulseLegal;
  assign enableD    = wrEnable ? (wrField & IMPL_MASK) : enableQ;
  assign hits       = pulseLegal & enableQ;
  assign captureNow = !lockQ && (|hits);

  // highest-numbered enabled line wins
  always_comb begin
    topIdx = '0;
    for (int k = 0; k < NUM_ERR; k++) begin
      if (hits[k]) topIdx = IDX_W'(k);
    end
  end

  always_comb begin
    strobe = '0;
    if (captureNow) begin
      if (CLASS_ALL[topIdx]) begin
        strobe = '{loadAddr: 1'b1, loadDest: 1'b1, loadSrc: 1'b1, loadCtrl: 1'b1};
      end else if (CLASS_ADDR[topIdx]) begin
        strobe = '{loadAddr: 1'b1, loadDest: 1'b1, loadSrc: 1'b0, loadCtrl: 1'b0};
      end else begin
        strobe = '{loadAddr: 1'b0, loadDest: 1'b1, loadSrc: 1'b1, loadCtrl: 1'b1};
      end
    end
  end

  always_comb begin
    if (captureNow)          lockD = 1'b1;
    else if (detectD == '0)  lockD = 1'b0;
    else                     lockD = lockQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      detectQ <= '0;
      enableQ <= '0;
      lockQ   <= 1'b0;
    end else begin
      detectQ <= detectD;
      enableQ <= enableD;
      lockQ   <= lockD;
    end
  end

  assign irq = |(detectQ & enableQ);
endmodule

// File: rtl/errcap_dpath.sv
module errcap_dpath
  import errcap_pkg::*;
#(
  parameter int ADDR_W  = 29,
  parameter int XADDR_W = 2,
  parameter int ID_W    = 16,
  parameter bit WIDE_ID = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  capStrobe_t         strobe,
  input  logic [ADDR_W-1:0]  pktAddr,
  input  logic [XADDR_W-1:0] pktXaddr,
  input  logic [ID_W-1:0]    pktDestId,
  input  logic [ID_W-1:0]    pktSrcId,
  input  logic [3:0]         pktFtype,
  input  logic [3:0]         pktTtype,
  input  logic [7:0]         pktMsgInfo,
  output logic [REG_W-1:0]   capAddr,
  output logic [REG_W-1:0]   capDev,
  output logic [REG_W-1:0]   capCtrl
);
  localparam int HALF_W = ID_W / 2;
  localparam int PAD_W  = REG_W - ADDR_W - XADDR_W;
  localparam int CTRL_W = 16;

  logic [ADDR_W-1:0]  addrQ;
  logic [XADDR_W-1:0] xaddrQ;
  logic [HALF_W-1:0]  destLoQ, srcLoQ;
  logic [HALF_W-1:0]  destHi, srcHi;
  logic [3:0]         ftypeQ, ttypeQ;
  logic [7:0]         msgQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      xaddrQ  <= '0;
      destLoQ <= '0;
      srcLoQ  <= '0;
      ftypeQ  <= '0;
      ttypeQ  <= '0;
      msgQ    <= '0;
    end else begin
      if (strobe.loadAddr) begin
        addrQ  <= pktAddr;
        xaddrQ <= pktXaddr;
      end
      if (strobe.loadDest) destLoQ <= pktDestId[HALF_W-1:0];
      if (strobe.loadSrc)  srcLoQ  <= pktSrcId[HALF_W-1:0];
      if (strobe.loadCtrl) begin
        ftypeQ <= pktFtype;
        ttypeQ <= pktTtype;
        msgQ   <= pktMsgInfo;
      end
    end
  end

  generate
    if (WIDE_ID) begin : g_wideId
      logic [HALF_W-1:0] destHiQ, srcHiQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          destHiQ <= '0;
          srcHiQ  <= '0;
        end else begin
          if (strobe.loadDest) destHiQ <= pktDestId[ID_W-1:HALF_W];
          if (strobe.loadSrc)  srcHiQ  <= pktSrcId[ID_W-1:HALF_W];
        end
      end
      assign destHi = destHiQ;
      assign srcHi  = srcHiQ;
    end else begin : g_narrowId
      assign destHi = '0;
      assign srcHi  = '0;
    end
  endgenerate

  assign capAddr = {addrQ, {PAD_W{1'b0}}, xaddrQ};
  assign capDev  = {destHi, destLoQ, srcHi, srcLoQ};
  assign capCtrl = {ftypeQ, ttypeQ, msgQ, {CTRL_W{1'b0}}};
endmodule

// File: rtl/errcap_top.sv
module errcap_top
  import errcap_pkg::*;
#(
  parameter int ADDR_W  = 29,
  parameter int XADDR_W = 2,
  parameter int ID_W    = 16,
  parameter bit WIDE_ID = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_ERR-1:0]  errPulse,
  input  logic [ADDR_W-1:0]   pktAddr,
  input  logic [XADDR_W-1:0]  pktXaddr,
  input  logic [ID_W-1:0]     pktDestId,
  input  logic [ID_W-1:0]     pktSrcId,
  input  logic [3:0]          pktFtype,
  input  logic [3:0]          pktTtype,
  input  logic [7:0]          pktMsgInfo,
  input  logic [2:0]          regSel,
  input  logic                regWrEn,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  output logic                mntIrq
);
  logic [NUM_ERR-1:0] detectQ;
  logic [NUM_ERR-1:0] enableQ;
  logic               lockQ;
  capStrobe_t         strobe;
  logic [REG_W-1:0]   capAddr, capDev, capCtrl;
  logic               wrDetect, wrEnable;

  assign wrDetect = regWrEn && (regSel == SEL_DETECT);
  assign wrEnable = regWrEn && (regSel == SEL_ENABLE);

  errcap_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .errPulse (errPulse),
    .wrDetect (wrDetect),
    .wrEnable (wrEnable),
    .wrField  (regWrData[REG_W-1:ERR_LSB]),
    .detectQ  (detectQ),
    .enableQ  (enableQ),
    .lockQ    (lockQ),
    .strobe   (strobe),
    .irq      (mntIrq)
  );

  errcap_dpath #(
    .ADDR_W  (ADDR_W),
    .XADDR_W (XADDR_W),
    .ID_W    (ID_W),
    .WIDE_ID (WIDE_ID)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .pktAddr    (pktAddr),
    .pktXaddr   (pktXaddr),
    .pktDestId  (pktDestId),
    .pktSrcId   (pktSrcId),
    .pktFtype   (pktFtype),
    .pktTtype   (pktTtype),
    .pktMsgInfo (pktMsgInfo),
    .capAddr    (capAddr),
    .capDev     (capDev),
    .capCtrl    (capCtrl)
  );

  always_comb begin
    case (regSel)
      SEL_DETECT: regRdData = {detectQ, {ERR_LSB{1'b0}}};
      SEL_ENABLE: regRdData = {enableQ, {ERR_LSB{1'b0}}};
      SEL_ADDR:   regRdData = capAddr;
      SEL_DEVID:  regRdData = capDev;
      SEL_CTRL:   regRdData = capCtrl;
      default:    regRdData = '0;
    endcase
  end
endmodule

// File: rtl/errcap_chk.sv
module errcap_chk
  import errcap_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [NUM_ERR-1:0] errPulse,
  input logic [2:0]         regSel,
  input logic               regWrEn,
  input logic [REG_W-1:0]   regWrData,
  input logic [REG_W-1:0]   regRdData,
  input logic               mntIrq,
  input logic [NUM_ERR-1:0] detectQ,
  input logic [NUM_ERR-1:0] enableQ,
  input logic               lockQ,
  input logic [REG_W-1:0]   capAddr,
  input logic [REG_W-1:0]   capDev,
  input logic [REG_W-1:0]   capCtrl
);
  AST_PULSE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errPulse[0] |=> detectQ[0]); // R1

  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == 3'd0 || regSel == 3'd1) |-> (regRdData[29] == 1'b0 && regRdData[21:0] == '0)); // R2

  AST_IRQ_ON_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    ((|(errPulse & enableQ & IMPL_MASK)) && !(regWrEn && regSel == 3'd1)) |=> mntIrq); // R3

  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == 3'd0 && regWrData == '0 && errPulse == '0) |=> !mntIrq); // R4

  AST_CAPTURE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (lockQ && !(regWrEn && regSel == 3'd0)) |=>
      ($stable(capAddr) && $stable(capDev) && $stable(capCtrl))); // R5
endmodule

bind errcap_top errcap_chk u_chk (.*);

// File: tb/sim_errcap_top.sv
module sim_errcap_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  errPulse = '0;
  logic [28:0] pktAddr = '0;
  logic [1:0]  pktXaddr = '0;
  logic [15:0] pktDestId = '0, pktSrcId = '0;
  logic [3:0]  pktFtype = '0, pktTtype = '0;
  logic [7:0]  pktMsgInfo = '0;
  logic [2:0]  regSel = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData, rdNarrow;
  logic        mntIrq, irqNarrow;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] expAddr = '0, expDev = '0, expCtrl = '0;

  always #4 clk = ~clk;

  errcap_top #(.WIDE_ID(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .errPulse(errPulse), .pktAddr(pktAddr), .pktXaddr(pktXaddr),
    .pktDestId(pktDestId), .pktSrcId(pktSrcId), .pktFtype(pktFtype), .pktTtype(pktTtype),
    .pktMsgInfo(pktMsgInfo), .regSel(regSel), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .mntIrq(mntIrq));

  errcap_top #(.WIDE_ID(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .errPulse(errPulse), .pktAddr(pktAddr), .pktXaddr(pktXaddr),
    .pktDestId(pktDestId), .pktSrcId(pktSrcId), .pktFtype(pktFtype), .pktTtype(pktTtype),
    .pktMsgInfo(pktMsgInfo), .regSel(regSel), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(rdNarrow), .mntIrq(irqNarrow));

  // {enable lines, pulse lines}; line i = detect bit 22+i
  localparam logic [19:0] VEC [0:7] = '{
    {10'h3FF, 10'h200},  // I/O error response: all registers
    {10'h3FF, 10'h004},  // response timeout: address + destination
    {10'h3FF, 10'h020},  // illegal decode: device-ID + control
    {10'h000, 10'h001},  // disabled: nothing
    {10'h3FF, 10'h005},  // two at once, timeout highest
    {10'h004, 10'h244},  // three at once, only timeout enabled
    {10'h3FF, 10'h080},  // unimplemented line only
    {10'h100, 10'h140}   // message error enabled beats format error
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [2:0] sel, logic [31:0] data);
    @(negedge clk);
    regSel = sel; regWrData = data; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic regRead(logic [2:0] sel, output logic [31:0] val);
    regSel = sel;
    #1;
    val = regRdData;
  endtask

  task automatic setFields(int i);
    pktAddr    = 29'h0ABC_D00 + 29'(i * 29'h111);
    pktXaddr   = 2'(i);
    pktDestId  = 16'hA100 + 16'(i);
    pktSrcId   = 16'hB200 + 16'(i);
    pktFtype   = 4'(i + 2);
    pktTtype   = 4'(15 - i);
    pktMsgInfo = 8'h40 + 8'(i);
  endtask

  task automatic firePulse(logic [9:0] p);
    @(negedge clk);
    errPulse = p;
    @(negedge clk);
    errPulse = '0;
  endtask

  // model update from the requirements (R7, R8, R9, R10, R11)
  task automatic modelCapture(logic [9:0] hits);
    int top = -1;
    for (int k = 0; k < 10; k++) if (hits[k]) top = k;
    if (top < 0) return;
    if (top == 9 || top == 8 || top == 6) begin
      expAddr = {pktAddr, 1'b0, pktXaddr};
      expDev  = {pktDestId, pktSrcId};
      expCtrl = {pktFtype, pktTtype, pktMsgInfo, 16'h0};
    end else if (top == 2) begin
      expAddr = {pktAddr, 1'b0, pktXaddr};
      expDev[31:16] = pktDestId;
    end else begin
      expDev  = {pktDestId, pktSrcId};
      expCtrl = {pktFtype, pktTtype, pktMsgInfo, 16'h0};
    end
  endtask

  task automatic checkCaptures(string req);
    logic [31:0] v;
    regRead(3'd2, v); check({req, " addr"}, v, expAddr);
    regRead(3'd3, v); check({req, " devid"}, v, expDev);
    check({req, " R10 narrow devid"}, rdNarrow, expDev & 32'h00FF_00FF);
    regRead(3'd4, v); check({req, " ctrl"}, v, expCtrl);
  endtask

  initial begin : watchdog
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R13 reset state
    for (int s = 0; s < 8; s++) begin
      regRead(3'(s), v);
      check("R13 reset/unused select", v, 32'h0);
    end
    check("R13 reset irq", {31'h0, mntIrq}, 32'h0);

    // table walk
    for (int i = 0; i < 8; i++) begin
      logic [9:0] en, p, hits;
      en = VEC[i][19:10];
      p  = VEC[i][9:0];
      hits = en & p & 10'h37F;
      regWrite(3'd1, {en, 22'h0});
      regWrite(3'd0, 32'h0);
      setFields(i);
      firePulse(p);
      modelCapture(hits);
      regRead(3'd0, v);
      check("R1 R8 R12 detect", v, {p & 10'h37F, 22'h0});
      check("R3 R12 irq", {31'h0, mntIrq}, {31'h0, |hits});
      checkCaptures("R7 R8 R9 R11 R12");
    end

    // lock behaviour
    regWrite(3'd1, 32'hFFFF_FFFF);
    regRead(3'd1, v);
    check("R2 enable readback", v, 32'hDFC0_0000);
    regWrite(3'd0, 32'h0);
    setFields(20);
    firePulse(10'h200);
    modelCapture(10'h200);
    checkCaptures("R5 first capture");
    setFields(21);
    firePulse(10'h001);
    checkCaptures("R5 locked");
    check("R3 irq held", {31'h0, mntIrq}, 32'h1);

    // capture registers are read-only
    regWrite(3'd2, 32'hFFFF_FFFF);
    regWrite(3'd3, 32'hFFFF_FFFF);
    regWrite(3'd4, 32'hFFFF_FFFF);
    checkCaptures("R2 read-only captures");

    // detect written nonzero keeps the lock
    regWrite(3'd0, 32'hFFFF_FFFF);
    regRead(3'd0, v);
    check("R2 detect reserved zero", v, 32'hDFC0_0000);
    setFields(23);
    firePulse(10'h020);
    checkCaptures("R6 lock kept while detect nonzero");

    // release and re-arm
    regWrite(3'd0, 32'h0);
    check("R4 irq cleared", {31'h0, mntIrq}, 32'h0);
    setFields(22);
    firePulse(10'h004);
    modelCapture(10'h004);
    checkCaptures("R6 rearmed capture");
    check("R3 irq after rearm", {31'h0, mntIrq}, 32'h1);

    // disabled pulse while unlocked: no irq, no capture
    regWrite(3'd1, 32'h0);
    regWrite(3'd0, 32'h0);
    setFields(24);
    firePulse(10'h010);
    regRead(3'd0, v);
    check("R12 detect set when disabled", v, 32'h0400_0000);
    check("R12 no irq when disabled", {31'h0, mntIrq}, 32'h0);
    checkCaptures("R12 no capture when disabled");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule